// File: doc/BRIEF.md
# PS/2 Host Port Controller

This block is the host side of a PS/2 keyboard link. The keyboard clocks 11-bit frames towards the host: a start bit of 0, eight data bits with the least significant bit first, an odd parity bit and a stop bit of 1. The block oversamples the open-drain clock and data lines through synchronizers and shifts a data bit in on every falling clock edge. It checks the start bit, the stop bit and the parity of each frame. A byte that passes is steered by a mode register, either to a keystroke strobe or to a command-answer strobe.

To talk to the keyboard, a client hands over a command byte and an optional data byte through a valid/ready request port. The block holds the clock line low to silence the keyboard. It then drives the start bit, releases the clock and puts each further bit on the data line after each falling edge that the keyboard produces. When the last byte has gone out, the block switches itself into answer-receive mode and re-arms its receiver. The bytes the keyboard sends in reply are therefore never mistaken for keystrokes.

The request port is the only input with back-pressure. `cmd_ready_o` is high only while no send is in progress, and a request is taken in the cycle where `cmd_valid_i` and `cmd_ready_o` are both high. The received-byte strobes have no ready input, because a keyboard cannot be paused in the middle of a frame. Each strobe is a single-cycle pulse, and `rx_byte_o` holds its byte until the next delivery.

Top module: `ps2_host_port`

## Requirements
- R1: After reset the mode is none (0x00), `cmd_ready_o` is high, both line pull-downs are released and no strobe or error pulse is raised.
- R2: In receive-keys mode (mode 0x80) a good frame raises `scan_valid_o` for one cycle. The byte on `rx_byte_o` is bits 1..8 of the frame, taken as D0 first.
- R3: Parity is odd: the data bits plus the parity bit hold an odd count of ones. On a mismatch `parity_err_o` pulses, `rx_byte_o` becomes 0xFF, and neither `scan_valid_o` nor `ans_valid_o` is raised.
- R4: In mode none (0x00) a good frame is discarded: no strobe is raised and `rx_byte_o` is unchanged.
- R5: A pulse on `rx_arm_i` outside a send sets the mode to receive-keys (0x80). If the mode is already receive-answer (0x40), it stays at 0x40.
- R6: A send holds the clock low for at least `INHIBIT_CYC` cycles. It then releases the clock with data already low (the start bit). On successive device falling edges it drives D0..D7, the odd parity bit, and a stop bit of 1 (data released).
- R7: A request with a data byte of 0 sends only the command byte. A non-zero data byte is sent as a second complete frame directly after the command, and the stored data byte is then cleared.
- R8: When the last byte of a send has finished (after the device acknowledge clock), the mode becomes receive-answer (0x40). The next good frame then pulses `ans_valid_o`.
- R9: A frame whose start bit is 1 or whose stop bit is 0 is dropped with no strobe and no error pulse.
- R10: If the clock stays high for `IDLE_CYC` cycles in the middle of a frame, the partial frame is dropped, and the next complete frame is received correctly.
- R11: During a send the mode reads 0x20 (send-command) and `cmd_ready_o` is low. No further request is accepted until the send is over.
- R12: Re-arming the receiver or starting a send discards any partially received frame, so the next frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk_i | input | 1 | Level of the PS/2 clock line |
| ps2_dat_i | input | 1 | Level of the PS/2 data line |
| ps2_clk_low_o | output | 1 | High pulls the PS/2 clock line low |
| ps2_dat_low_o | output | 1 | High pulls the PS/2 data line low |
| rx_arm_i | input | 1 | Pulse: re-arm the receiver |
| cmd_valid_i | input | 1 | Send request valid |
| cmd_ready_o | output | 1 | Send request can be accepted |
| cmd_byte_i | input | 8 | Command byte to send |
| cmd_data_i | input | 8 | Optional data byte, 0 means none |
| scan_valid_o | output | 1 | Pulse: keystroke byte on `rx_byte_o` |
| ans_valid_o | output | 1 | Pulse: answer byte on `rx_byte_o` |
| rx_byte_o | output | 8 | Last delivered byte, 0xFF after parity error |
| parity_err_o | output | 1 | Pulse: received frame failed odd parity |
| mode_o | output | 8 | Mode: 0x80 keys, 0x40 answer, 0x20 send, 0x00 none |

## Verification
The bench builds the block with `INHIBIT_CYC` = 40 and `IDLE_CYC` = 200 and keeps two synchronizer stages. With these values the keyboard model can run a bit period of 40 system cycles. The whole clock-inhibit phase can be measured against its bound in a few dozen cycles. A 300-cycle gap in the middle of a frame is enough to trigger the idle drop. The same model both sends frames and clocks out two-byte commands, so the command chaining and the automatic switch to answer mode are reached within a few thousand cycles.

// File: rtl/ps2_host_pkg.sv
package ps2_host_pkg;

  localparam logic [7:0] MODE_NONE = 8'h00;
  localparam logic [7:0] MODE_KEYS = 8'h80;
  localparam logic [7:0] MODE_ANS  = 8'h40;
  localparam logic [7:0] MODE_SEND = 8'h20;

  localparam int FRAME_BITS = 11;

  typedef enum logic [1:0] {
    TX_IDLE    = 2'd0,
    TX_INHIBIT = 2'd1,
    TX_SHIFT   = 2'd2
  } tx_state_t;

  // Odd parity: the bit that makes data plus parity carry an odd count of ones.
  function automatic logic odd_par(input logic [7:0] d);
    return ~(^d);
  endfunction

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain_q;

  generate
    for (genvar g = 0; g < N; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= line_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign level_o = chain_q[N-1];
endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame #(
  parameter int IDLE_CYC = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       fall_i,
  input  logic       dat_i,
  output logic       done_o,
  output logic [7:0] byte_o,
  output logic       par_ok_o
);
  import ps2_host_pkg::*;

  localparam int IW = (IDLE_CYC > 1) ? $clog2(IDLE_CYC) : 1;
  localparam logic [3:0] LAST_BIT = 4'(FRAME_BITS - 1);

  logic [9:0]    sr_q;
  logic [3:0]    cnt_q;
  logic [IW-1:0] idle_q;
  logic [10:0]   full;

  assign full = {dat_i, sr_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q     <= '0;
      cnt_q    <= '0;
      idle_q   <= '0;
      done_o   <= 1'b0;
      byte_o   <= '0;
      par_ok_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (clear_i) begin
        cnt_q  <= '0;
        idle_q <= '0;
      end else if (fall_i) begin
        idle_q <= '0;
        if (cnt_q == LAST_BIT) begin
          cnt_q    <= '0;
          done_o   <= ~full[0] & full[10];
          byte_o   <= full[8:1];
          par_ok_o <= ^full[9:1];
        end else begin
          sr_q  <= {dat_i, sr_q[9:1]};
          cnt_q <= cnt_q + 4'd1;
        end
      end else if (cnt_q != 4'd0) begin
        if (idle_q == IW'(IDLE_CYC - 1)) begin
          cnt_q  <= '0;
          idle_q <= '0;
        end else begin
          idle_q <= idle_q + 1'b1;
        end
      end
    end
  end

  a_r10_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_BIT);
  a_r12_clear_drops_partial: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == 4'd0 && !done_o));
endmodule

// File: rtl/ps2_tx_frame.sv
module ps2_tx_frame #(
  parameter int INHIBIT_CYC = 25000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic       fall_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       clk_low_o,
  output logic       dat_low_o
);
  import ps2_host_pkg::*;

  localparam int CW = (INHIBIT_CYC > 1) ? $clog2(INHIBIT_CYC) : 1;
  localparam logic [3:0] SHIFT_BITS = 4'(FRAME_BITS - 1);

  tx_state_t     st_q;
  logic [CW-1:0] inh_q;
  logic [9:0]    sh_q;
  logic [3:0]    bitn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= TX_IDLE;
      inh_q     <= '0;
      sh_q      <= '0;
      bitn_q    <= '0;
      done_o    <= 1'b0;
      dat_low_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        TX_IDLE: begin
          dat_low_o <= 1'b0;
          if (start_i) begin
            st_q   <= TX_INHIBIT;
            inh_q  <= '0;
            sh_q   <= {1'b1, odd_par(byte_i), byte_i};
            bitn_q <= '0;
          end
        end
        TX_INHIBIT: begin
          if (inh_q == CW'(INHIBIT_CYC - 1)) begin
            st_q      <= TX_SHIFT;
            dat_low_o <= 1'b1;
          end else begin
            inh_q <= inh_q + 1'b1;
          end
        end
        TX_SHIFT: begin
          if (fall_i) begin
            if (bitn_q == SHIFT_BITS) begin
              st_q      <= TX_IDLE;
              done_o    <= 1'b1;
              dat_low_o <= 1'b0;
            end else begin
              dat_low_o <= ~sh_q[0];
              sh_q      <= {1'b0, sh_q[9:1]};
              bitn_q    <= bitn_q + 4'd1;
            end
          end
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != TX_IDLE);
  assign clk_low_o = (st_q == TX_INHIBIT);

  a_r6_data_held_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_SHIFT && !fall_i) |=> $stable(dat_low_o));
  a_r6_start_bit_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_low_o) |-> dat_low_o);
  a_r6_data_free_while_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    clk_low_o |-> !dat_low_o);
endmodule

// File: rtl/ps2_port_ctrl.sv
module ps2_port_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid_i,
  output logic       cmd_ready_o,
  input  logic [7:0] cmd_byte_i,
  input  logic [7:0] cmd_data_i,
  input  logic       rx_arm_i,
  input  logic       rx_done_i,
  input  logic [7:0] rx_byte_i,
  input  logic       rx_par_ok_i,
  input  logic       tx_busy_i,
  input  logic       tx_done_i,
  output logic       tx_start_o,
  output logic [7:0] tx_byte_o,
  output logic       rx_clear_o,
  output logic [7:0] mode_o,
  output logic       scan_valid_o,
  output logic       ans_valid_o,
  output logic [7:0] out_byte_o,
  output logic       parity_err_o
);
  import ps2_host_pkg::*;

  logic [7:0] mode_q;
  logic [7:0] pend_q;
  logic       accept;

  assign cmd_ready_o = (mode_q != MODE_SEND) && !tx_busy_i;
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign rx_clear_o  = rx_arm_i || accept || (mode_q == MODE_SEND);
  assign mode_o      = mode_q;

  // Mode register and send sequencing.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= MODE_NONE;
      pend_q     <= '0;
      tx_start_o <= 1'b0;
      tx_byte_o  <= '0;
    end else begin
      tx_start_o <= 1'b0;
      if (mode_q == MODE_SEND) begin
        if (tx_done_i) begin
          if (pend_q != 8'h00) begin
            tx_start_o <= 1'b1;
            tx_byte_o  <= pend_q;
            pend_q     <= 8'h00;
          end else begin
            mode_q <= MODE_ANS;
          end
        end
      end else if (accept) begin
        mode_q     <= MODE_SEND;
        tx_start_o <= 1'b1;
        tx_byte_o  <= cmd_byte_i;
        pend_q     <= cmd_data_i;
      end else if (rx_arm_i && mode_q != MODE_ANS) begin
        mode_q <= MODE_KEYS;
      end
    end
  end

  // Routing of received bytes.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_valid_o <= 1'b0;
      ans_valid_o  <= 1'b0;
      parity_err_o <= 1'b0;
      out_byte_o   <= '0;
    end else begin
      scan_valid_o <= 1'b0;
      ans_valid_o  <= 1'b0;
      parity_err_o <= 1'b0;
      if (rx_done_i) begin
        if (!rx_par_ok_i) begin
          out_byte_o   <= 8'hFF;
          parity_err_o <= 1'b1;
        end else if (mode_q == MODE_KEYS) begin
          out_byte_o   <= rx_byte_i;
          scan_valid_o <= 1'b1;
        end else if (mode_q == MODE_ANS) begin
          out_byte_o  <= rx_byte_i;
          ans_valid_o <= 1'b1;
        end
      end
    end
  end

  a_r3_error_not_routed: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err_o |-> (!scan_valid_o && !ans_valid_o && out_byte_o == 8'hFF));
  a_r5_mode_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode_q));
  a_r5_answer_kept_on_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ANS && rx_arm_i && !cmd_valid_i) |=> mode_q == MODE_ANS);
  a_r11_no_ready_in_send: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SEND) |-> !cmd_ready_o);
  a_r8_send_ends_in_answer: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == MODE_SEND && mode_q != MODE_SEND) |-> mode_q == MODE_ANS);
  a_r4_no_strobe_in_none: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_NONE && $past(mode_q) == MODE_NONE) |-> (!scan_valid_o && !ans_valid_o));
endmodule

// File: rtl/ps2_host_port.sv
module ps2_host_port #(
  parameter int SYNC_STAGES = 2,
  parameter int INHIBIT_CYC = 25000,
  parameter int IDLE_CYC    = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       ps2_clk_low_o,
  output logic       ps2_dat_low_o,
  input  logic       rx_arm_i,
  input  logic       cmd_valid_i,
  output logic       cmd_ready_o,
  input  logic [7:0] cmd_byte_i,
  input  logic [7:0] cmd_data_i,
  output logic       scan_valid_o,
  output logic       ans_valid_o,
  output logic [7:0] rx_byte_o,
  output logic       parity_err_o,
  output logic [7:0] mode_o
);
  logic       clk_lvl, dat_lvl, clk_prev_q, clk_fall;
  logic       rx_clear, rx_done, rx_par_ok;
  logic [7:0] rx_byte;
  logic       tx_start, tx_busy, tx_done;
  logic [7:0] tx_byte;

  ps2_line_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .line_i(ps2_clk_i), .level_o(clk_lvl));
  ps2_line_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .line_i(ps2_dat_i), .level_o(dat_lvl));

  always_ff @(posedge clk) begin
    if (!rst_n) clk_prev_q <= 1'b1;
    else        clk_prev_q <= clk_lvl;
  end
  assign clk_fall = clk_prev_q & ~clk_lvl;

  ps2_rx_frame #(.IDLE_CYC(IDLE_CYC)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear_i(rx_clear), .fall_i(clk_fall),
    .dat_i(dat_lvl), .done_o(rx_done), .byte_o(rx_byte), .par_ok_o(rx_par_ok));

  ps2_tx_frame #(.INHIBIT_CYC(INHIBIT_CYC)) u_tx (
    .clk(clk), .rst_n(rst_n), .start_i(tx_start), .byte_i(tx_byte),
    .fall_i(clk_fall), .busy_o(tx_busy), .done_o(tx_done),
    .clk_low_o(ps2_clk_low_o), .dat_low_o(ps2_dat_low_o));

  ps2_port_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_byte_i(cmd_byte_i), .cmd_data_i(cmd_data_i), .rx_arm_i(rx_arm_i),
    .rx_done_i(rx_done), .rx_byte_i(rx_byte), .rx_par_ok_i(rx_par_ok),
    .tx_busy_i(tx_busy), .tx_done_i(tx_done), .tx_start_o(tx_start),
    .tx_byte_o(tx_byte), .rx_clear_o(rx_clear), .mode_o(mode_o),
    .scan_valid_o(scan_valid_o), .ans_valid_o(ans_valid_o),
    .out_byte_o(rx_byte_o), .parity_err_o(parity_err_o));

  a_r1_lines_free_in_reset: assert property (@(posedge clk)
    !rst_n |=> (!ps2_clk_low_o && !ps2_dat_low_o));
endmodule

// File: tb/ps2_host_port_tb.sv
`timescale 1ns/1ps
module ps2_host_port_tb;
  localparam int INH  = 40;
  localparam int IDLE = 200;
  localparam int H    = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_clk = 1'b1, dev_dat = 1'b1;
  logic rx_arm = 1'b0, cmd_valid = 1'b0;
  logic [7:0] cmd_byte = '0, cmd_data = '0;
  logic clk_low, dat_low, cmd_ready, scan_valid, ans_valid, perr;
  logic [7:0] rx_byte, mode;
  logic clk_line, dat_line;

  always #2 clk = ~clk;

  assign clk_line = dev_clk & ~clk_low;
  assign dat_line = dev_dat & ~dat_low;

  ps2_host_port #(.SYNC_STAGES(2), .INHIBIT_CYC(INH), .IDLE_CYC(IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(clk_line), .ps2_dat_i(dat_line),
    .ps2_clk_low_o(clk_low), .ps2_dat_low_o(dat_low), .rx_arm_i(rx_arm),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_byte_i(cmd_byte),
    .cmd_data_i(cmd_data), .scan_valid_o(scan_valid), .ans_valid_o(ans_valid),
    .rx_byte_o(rx_byte), .parity_err_o(perr), .mode_o(mode));

  int checks = 0, failures = 0;
  int scan_cnt = 0, ans_cnt = 0, perr_cnt = 0;
  logic [7:0] scan_last = '0, ans_last = '0;
  int run = 0, inhib_last = 0, inhib_runs = 0;
  bit finished = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (scan_valid) begin scan_cnt++; scan_last = rx_byte; end
      if (ans_valid)  begin ans_cnt++;  ans_last  = rx_byte; end
      if (perr) perr_cnt++;
      if (clk_low) run++;
      else if (run > 0) begin inhib_last = run; inhib_runs++; run = 0; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Keyboard drives one bit: data set, then a falling and a rising clock edge.
  task automatic dev_bit(input logic b);
    dev_dat = b; waitn(H);
    dev_clk = 1'b0; waitn(H);
    dev_clk = 1'b1;
  endtask

  task automatic dev_frame(input logic [7:0] d, input bit bad_par,
                           input bit bad_start, input bit bad_stop);
    logic [10:0] f;
    f = {~bad_stop, (~(^d)) ^ bad_par, d, bad_start};
    for (int i = 0; i < 11; i++) dev_bit(f[i]);
    dev_dat = 1'b1;
    waitn(10);
  endtask

  task automatic arm();
    rx_arm = 1'b1; waitn(1); rx_arm = 1'b0; waitn(2);
  endtask

  // Keyboard side of one host-to-device frame; returns the 11 line levels.
  task automatic host_frame(output logic [10:0] got, output bit ok);
    int lim;
    ok = 1;
    lim = 0;
    while (!clk_low && lim < 2000) begin waitn(1); lim++; end
    while (clk_low && lim < 2000) begin waitn(1); lim++; end
    if (lim >= 2000) ok = 0;
    got[0] = dat_line;
    for (int k = 1; k < 11; k++) begin
      waitn(H);
      dev_clk = 1'b0; waitn(H);
      got[k] = dat_line;
      dev_clk = 1'b1;
    end
    waitn(H);
    dev_dat = 1'b0; dev_clk = 1'b0; waitn(H);
    dev_clk = 1'b1; dev_dat = 1'b1;
  endtask

  task automatic check_frame(input logic [10:0] got, input logic [7:0] d, input string req);
    check(got[0] == 1'b0, {req, " start bit"}, got[0], 0);
    check(got[8:1] == d, {req, " data bits"}, got[8:1], d);
    check(got[9] == ~(^d), {req, " odd parity"}, got[9], ~(^d));
    check(got[10] == 1'b1, {req, " stop bit"}, got[10], 1);
    check(inhib_last >= INH, {req, " inhibit length"}, inhib_last, INH);
  endtask

  task automatic request(input logic [7:0] c, input logic [7:0] d);
    cmd_byte = c; cmd_data = d; cmd_valid = 1'b1;
    while (!cmd_ready) waitn(1);
    waitn(1);
    cmd_valid = 1'b0;
    waitn(2);
  endtask

  task automatic t_reset();
    check(mode == 8'h00, "R1 mode", mode, 0);
    check(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    check(!clk_low && !dat_low, "R1 lines", {clk_low, dat_low}, 0);
    check(!scan_valid && !ans_valid && !perr, "R1 strobes", {scan_valid, ans_valid, perr}, 0);
  endtask

  task automatic t_none_discard();
    dev_frame(8'h1C, 0, 0, 0);
    check(scan_cnt == 0 && ans_cnt == 0, "R4 discard in none", scan_cnt + ans_cnt, 0);
    check(rx_byte == 8'h00, "R4 byte unchanged", rx_byte, 0);
  endtask

  task automatic t_keys();
    arm();
    check(mode == 8'h80, "R5 arm to keys", mode, 8'h80);
    dev_frame(8'h1C, 0, 0, 0);
    check(scan_cnt == 1 && scan_last == 8'h1C, "R2 scancode 1C", scan_last, 8'h1C);
    dev_frame(8'hA5, 0, 0, 0);
    check(scan_cnt == 2 && scan_last == 8'hA5, "R2 scancode A5", scan_last, 8'hA5);
    dev_frame(8'h00, 0, 0, 0);
    check(scan_cnt == 3 && scan_last == 8'h00, "R2 scancode 00", scan_last, 8'h00);
  endtask

  task automatic t_parity();
    dev_frame(8'h33, 1, 0, 0);
    check(perr_cnt == 1, "R3 parity error pulse", perr_cnt, 1);
    check(rx_byte == 8'hFF, "R3 byte forced FF", rx_byte, 8'hFF);
    check(scan_cnt == 3 && ans_cnt == 0, "R3 not routed", scan_cnt, 3);
  endtask

  task automatic t_framing();
    dev_frame(8'h44, 0, 1, 0);
    dev_frame(8'h45, 0, 0, 1);
    check(scan_cnt == 3 && perr_cnt == 1, "R9 framing dropped", scan_cnt, 3);
    dev_frame(8'h29, 0, 0, 0);
    check(scan_cnt == 4 && scan_last == 8'h29, "R9 next frame ok", scan_last, 8'h29);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 4; i++) dev_bit(1'b0);
    dev_dat = 1'b1;
    waitn(IDLE + 100);
    dev_frame(8'h5A, 0, 0, 0);
    check(scan_cnt == 5 && scan_last == 8'h5A, "R10 idle drop", scan_last, 8'h5A);
  endtask

  task automatic t_cancel();
    for (int i = 0; i < 4; i++) dev_bit(1'b1);
    dev_dat = 1'b1;
    arm();
    dev_frame(8'h66, 0, 0, 0);
    check(scan_cnt == 6 && scan_last == 8'h66, "R12 arm cancels partial", scan_last, 8'h66);
  endtask

  task automatic t_cmd_single();
    logic [10:0] got;
    bit ok;
    int runs0;
    for (int i = 0; i < 3; i++) dev_bit(1'b1);
    dev_dat = 1'b1;
    request(8'hF4, 8'h00);
    check(mode == 8'h20, "R11 mode send", mode, 8'h20);
    check(cmd_ready == 1'b0, "R11 ready low", cmd_ready, 0);
    host_frame(got, ok);
    check(ok, "R6 clock released", ok, 1);
    check_frame(got, 8'hF4, "R6");
    runs0 = inhib_runs;
    waitn(200);
    check(inhib_runs == runs0, "R7 single byte only", inhib_runs, runs0);
    check(mode == 8'h40, "R8 answer mode", mode, 8'h40);
    dev_frame(8'hFA, 0, 0, 0);
    check(ans_cnt == 1 && ans_last == 8'hFA, "R8 answer routed", ans_last, 8'hFA);
    check(scan_cnt == 6, "R12 partial dropped on send", scan_cnt, 6);
    arm();
    check(mode == 8'h40, "R5 answer kept", mode, 8'h40);
  endtask

  task automatic t_cmd_pair();
    logic [10:0] g1, g2;
    bit ok1, ok2;
    request(8'hED, 8'h02);
    host_frame(g1, ok1);
    check_frame(g1, 8'hED, "R7 first");
    host_frame(g2, ok2);
    check(ok1 && ok2, "R7 two frames", {ok1, ok2}, 3);
    check_frame(g2, 8'h02, "R7 second");
    waitn(20);
    check(mode == 8'h40 && cmd_ready, "R8 answer after pair", mode, 8'h40);
  endtask

  initial begin
    waitn(5);
    rst_n = 1'b1;
    waitn(3);
    t_reset();
    t_none_discard();
    t_keys();
    t_parity();
    t_framing();
    t_idle();
    t_cancel();
    t_cmd_single();
    t_cmd_pair();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule